// File: doc/BRIEF.md
# Eight-Source Two-Level Interrupt Controller

This block gathers eight interrupt requests for a small 8-bit CPU core. Four of them come from active-low external pins. Three come from timer overflow logic, and one comes from the serial port. Each source passes through a global enable and its own enable. A per-source priority bit then puts it in the high or the low level. When several sources are pending at the same level, a fixed polling order picks one. The block presents that choice to the CPU as a request line and a vector address.

The CPU pulses `cpu_ack` when it vectors to a request, and `cpu_reti` when it returns from the service routine. A small service-state machine tracks what is being served. A low-level service can be preempted by a high-level request. A high-level service blocks everything until it returns. The machine has four states:
- `SVC_IDLE`: nothing is in service.
- `SVC_LOW`: a low-level routine is running.
- `SVC_HIGH`: a high-level routine entered from idle is running.
- `SVC_NEST`: a high-level routine has preempted a low-level one.

The transitions are:
- take-low: `SVC_IDLE` to `SVC_LOW`.
- take-high: `SVC_IDLE` to `SVC_HIGH`.
- preempt: `SVC_LOW` to `SVC_NEST`.
- return: `SVC_LOW` or `SVC_HIGH` to `SVC_IDLE`.
- unnest: `SVC_NEST` to `SVC_LOW`.

Each external pin can be set to falling-edge or low-level triggering. In edge mode the block keeps a request flag. Hardware sets the flag when it sees an edge, and clears it when that source is acknowledged.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset the following hold. `irq_req` is 0, `ext_flag` is 0 and both `svc_lo` and `svc_hi` are 0. The stored history of every pin is high.
- R2: Slot numbers run 0 to 7 and serve these sources in order: ext0, timer0, ext1, timer1, serial, timer2, ext2, ext3. The vector of slot s is 8*s+3, which gives 03H, 0BH, 13H, 1BH, 23H, 2BH, 33H and 3BH. Bit s of `src_en` and of `src_hi` belongs to slot s.
- R3: Among pending sources of one level, the lowest slot wins. When the state allows both levels, any eligible high-level source wins over any low-level source.
- R4: `irq_req` is 0 whenever `glob_en` is 0. A source whose `src_en` bit is 0 is never chosen.
- R5: Bit k of `ext_edge_mode` and `ext_pin_n` belongs to ext k, where k = 0, 1, 2, 3 and `ext_flag` uses the same order. With the mode bit at 1, an edge is a pin sampled high on one clock and low on the next. On that clock `ext_flag[k]` is set, and it becomes visible after the edge. With the mode bit at 0, the source's request is the inverse of the pin, passed through without any latch.
- R6: `ext_flag[k]` is cleared when the CPU acknowledges the slot of ext k. If a new edge arrives in the same cycle, the flag stays set.
- R7: The timer2 request is `tmr2_ovf | tmr2_ext`. The block never clears it, so it stays pending for as long as either input stays high.
- R8: An acknowledge moves the state machine as follows: from idle it goes to `SVC_HIGH` for a high-level winner and to `SVC_LOW` for a low-level winner, and from `SVC_LOW` it goes to `SVC_NEST`. A return moves `SVC_NEST` to `SVC_LOW`, and moves `SVC_LOW` or `SVC_HIGH` to idle. `svc_lo` is 1 in `SVC_LOW` and `SVC_NEST`. `svc_hi` is 1 in `SVC_HIGH` and `SVC_NEST`.
- R9: In `SVC_LOW` only high-level sources can raise `irq_req`. In `SVC_HIGH` and `SVC_NEST`, `irq_req` is 0.
- R10: An acknowledge has no effect in three cases: while `irq_req` is 0, while `cpu_reti` is high in the same cycle, and for a return made in idle. In all three cases the state and the flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glob_en | input | 1 | Global interrupt enable |
| src_en | input | 8 | Per-slot enable |
| src_hi | input | 8 | Per-slot priority, 1 = high level |
| ext_edge_mode | input | 4 | Per external pin: 1 = falling edge, 0 = low level |
| ext_pin_n | input | 4 | External request pins, active low |
| tmr0_ovf | input | 1 | Timer 0 overflow request |
| tmr1_ovf | input | 1 | Timer 1 overflow request |
| uart_req | input | 1 | Serial port request |
| tmr2_ovf | input | 1 | Timer 2 overflow flag |
| tmr2_ext | input | 1 | Timer 2 external flag |
| cpu_ack | input | 1 | CPU vectors to the current request |
| cpu_reti | input | 1 | CPU returns from a service routine |
| irq_req | output | 1 | Request to the CPU |
| irq_vector | output | 8 | Vector address of the winning slot |
| ext_flag | output | 4 | Edge request flags of ext0..ext3 |
| svc_lo | output | 1 | A low-level service is open |
| svc_hi | output | 1 | A high-level service is open |

## Verification
The assertions take for granted that `cpu_ack` and `cpu_reti` are single-cycle strobes sampled on the rising clock edge. They also take for granted that every input is stable around that edge. They assume the CPU is free to pulse either strobe at any time, including with no request pending or in the idle state. The bench changes every input one time unit after the rising edge. Its random phase pulses the strobes with no regard to the state, so the ignore rules of R10 are reached without being steered.

// File: rtl/irq_ctrl8_pkg.sv
package irq_ctrl8_pkg;
    localparam int N_SRC = 8;
    localparam int N_EXT = 4;

    typedef enum logic [1:0] {
        SVC_IDLE,
        SVC_LOW,
        SVC_HIGH,
        SVC_NEST
    } svc_state_e;

    // polling slot that serves external input k
    function automatic int ext_slot(input int k);
        case (k)
            0:       return 0;
            1:       return 2;
            2:       return 6;
            default: return 7;
        endcase
    endfunction
endpackage

// File: rtl/irq_ext_latch.sv
module irq_ext_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic flag,
    output logic req
);
    logic pin_q;
    logic fall;

    assign fall = edge_mode && pin_q && !pin_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b1;
            flag  <= 1'b0;
        end else begin
            pin_q <= pin_n;
            if (fall)
                flag <= 1'b1;
            else if (clr)
                flag <= 1'b0;
        end
    end

    assign req = edge_mode ? flag : !pin_n;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     pend,
    input  logic [N-1:0]     hi,
    input  logic             allow_lo,
    input  logic             allow_hi,
    output logic             valid,
    output logic             win_hi,
    output logic [IDX_W-1:0] idx
);
    logic             hv, lv;
    logic [IDX_W-1:0] hi_idx, lo_idx;

    always_comb begin
        hv = 1'b0;
        lv = 1'b0;
        hi_idx = '0;
        lo_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i] && hi[i]) begin
                hv = 1'b1;
                hi_idx = IDX_W'(i);
            end
            if (pend[i] && !hi[i]) begin
                lv = 1'b1;
                lo_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        win_hi = allow_hi && hv;
        valid  = win_hi || (allow_lo && lv);
        idx    = win_hi ? hi_idx : lo_idx;
    end
endmodule

// File: rtl/irq_nest_fsm.sv
module irq_nest_fsm
    import irq_ctrl8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic take_hi,
    input  logic reti,
    output logic allow_lo,
    output logic allow_hi,
    output logic svc_lo,
    output logic svc_hi
);
    svc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SVC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SVC_IDLE: if (take)      state_d = take_hi ? SVC_HIGH : SVC_LOW;
            SVC_LOW:  if (reti)      state_d = SVC_IDLE;
                      else if (take) state_d = SVC_NEST;
            SVC_HIGH: if (reti)      state_d = SVC_IDLE;
            SVC_NEST: if (reti)      state_d = SVC_LOW;
        endcase
    end

    always_comb begin
        allow_lo = 1'b0;
        allow_hi = 1'b0;
        svc_lo   = 1'b0;
        svc_hi   = 1'b0;
        unique case (state_q)
            SVC_IDLE: begin allow_lo = 1'b1; allow_hi = 1'b1; end
            SVC_LOW:  begin allow_hi = 1'b1; svc_lo = 1'b1; end
            SVC_HIGH: svc_hi = 1'b1;
            SVC_NEST: begin svc_lo = 1'b1; svc_hi = 1'b1; end
        endcase
    end
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8
    import irq_ctrl8_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glob_en,
    input  logic [7:0]       src_en,
    input  logic [7:0]       src_hi,
    input  logic [3:0]       ext_edge_mode,
    input  logic [3:0]       ext_pin_n,
    input  logic             tmr0_ovf,
    input  logic             tmr1_ovf,
    input  logic             uart_req,
    input  logic             tmr2_ovf,
    input  logic             tmr2_ext,
    input  logic             cpu_ack,
    input  logic             cpu_reti,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vector,
    output logic [3:0]       ext_flag,
    output logic             svc_lo,
    output logic             svc_hi
);
    localparam int IDX_W = $clog2(N_SRC);
    localparam int PAD_W = VEC_W - IDX_W - 3;

    logic [N_EXT-1:0] ext_req;
    logic [N_SRC-1:0] raw, pend;
    logic [IDX_W-1:0] win_idx;
    logic             win_hi, allow_lo, allow_hi, take;

    assign take = cpu_ack && irq_req && !cpu_reti;

    for (genvar k = 0; k < N_EXT; k++) begin : g_ext
        localparam int SLOT = ext_slot(k);
        irq_ext_latch u_latch (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_pin_n[k]),
            .edge_mode (ext_edge_mode[k]),
            .clr       (take && (win_idx == IDX_W'(SLOT))),
            .flag      (ext_flag[k]),
            .req       (ext_req[k])
        );
    end

    always_comb begin
        raw  = {ext_req[3], ext_req[2], tmr2_ovf | tmr2_ext, uart_req,
                tmr1_ovf, ext_req[1], tmr0_ovf, ext_req[0]};
        pend = raw & src_en & {N_SRC{glob_en}};
    end

    irq_arbiter #(.N(N_SRC), .IDX_W(IDX_W)) u_arb (
        .pend     (pend),
        .hi       (src_hi),
        .allow_lo (allow_lo),
        .allow_hi (allow_hi),
        .valid    (irq_req),
        .win_hi   (win_hi),
        .idx      (win_idx)
    );

    irq_nest_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .take_hi  (win_hi),
        .reti     (cpu_reti),
        .allow_lo (allow_lo),
        .allow_hi (allow_hi),
        .svc_lo   (svc_lo),
        .svc_hi   (svc_hi)
    );

    assign irq_vector = {{PAD_W{1'b0}}, win_idx, 3'b011};
endmodule

// File: rtl/irq_ctrl8_chk.sv
module irq_ctrl8_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       glob_en,
    input logic [7:0] src_hi,
    input logic [3:0] ext_edge_mode,
    input logic [3:0] ext_pin_n,
    input logic       cpu_ack,
    input logic       cpu_reti,
    input logic       irq_req,
    input logic [7:0] irq_vector,
    input logic [3:0] ext_flag,
    input logic       svc_lo,
    input logic       svc_hi
);
    p_vec_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vector[2:0] == 3'b011 && irq_vector[7:6] == 2'b00));

    p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> !irq_req);

    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_flag[2]) |-> $past(!ext_pin_n[2] && ext_edge_mode[2]));

    p_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && irq_req && !cpu_reti && !svc_lo && !svc_hi) |=> (svc_lo != svc_hi));

    p_unnest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_reti && svc_lo && svc_hi) |=> (svc_lo && !svc_hi));

    p_high_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        svc_hi |-> !irq_req);

    p_low_preempt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && svc_lo) |-> src_hi[irq_vector[5:3]]);

    p_ack_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && !irq_req && !svc_lo && !svc_hi) |=> (!svc_lo && !svc_hi));
endmodule

bind irq_ctrl8 irq_ctrl8_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .glob_en       (glob_en),
    .src_hi        (src_hi),
    .ext_edge_mode (ext_edge_mode),
    .ext_pin_n     (ext_pin_n),
    .cpu_ack       (cpu_ack),
    .cpu_reti      (cpu_reti),
    .irq_req       (irq_req),
    .irq_vector    (irq_vector),
    .ext_flag      (ext_flag),
    .svc_lo        (svc_lo),
    .svc_hi        (svc_hi)
);

// File: tb/test_irq_ctrl8.sv
module test_irq_ctrl8;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       glob_en = 1'b0;
    logic [7:0] src_en = '0, src_hi = '0;
    logic [3:0] ext_edge_mode = '0, ext_pin_n = 4'hF;
    logic       tmr0_ovf = 0, tmr1_ovf = 0, uart_req = 0, tmr2_ovf = 0, tmr2_ext = 0;
    logic       cpu_ack = 0, cpu_reti = 0;
    logic       irq_req, svc_lo, svc_hi;
    logic [7:0] irq_vector;
    logic [3:0] ext_flag;

    int  n_cmp = 0, n_bad = 0, cyc = 0;
    bit  chk_on = 0;
    bit  m_lo = 0, m_hi = 0;
    bit  m_prev[4] = '{1, 1, 1, 1};
    bit  m_flag[4] = '{0, 0, 0, 0};
    int  ext_at[4] = '{0, 2, 6, 7};

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_ctrl8 i_irq_ctrl8 (.*);

    function automatic bit ext_raw(int k);
        return ext_edge_mode[k] ? m_flag[k] : !ext_pin_n[k];
    endfunction

    function automatic bit raw_of(int s);
        case (s)
            0: return ext_raw(0);
            1: return tmr0_ovf;
            2: return ext_raw(1);
            3: return tmr1_ovf;
            4: return uart_req;
            5: return tmr2_ovf || tmr2_ext;
            6: return ext_raw(2);
            default: return ext_raw(3);
        endcase
    endfunction

    function automatic void model_win(output bit v, output int s, output bit h);
        bit hv = 0, lv = 0;
        int hs = 0, ls = 0;
        for (int i = 7; i >= 0; i--) begin
            if (glob_en && src_en[i] && raw_of(i)) begin
                if (src_hi[i]) begin hv = 1; hs = i; end
                else begin lv = 1; ls = i; end
            end
        end
        if (!m_hi && hv)               begin v = 1; s = hs; h = 1; end
        else if (!m_lo && !m_hi && lv) begin v = 1; s = ls; h = 0; end
        else                           begin v = 0; s = 0;  h = 0; end
    endfunction

    // reference state update
    always @(posedge clk) begin
        bit v, h, take;
        int s;
        if (!rst_n) begin
            m_lo = 0; m_hi = 0;
            for (int k = 0; k < 4; k++) begin m_prev[k] = 1; m_flag[k] = 0; end
        end else begin
            model_win(v, s, h);
            take = cpu_ack && v && !cpu_reti;
            for (int k = 0; k < 4; k++) begin
                if (ext_edge_mode[k] && m_prev[k] && !ext_pin_n[k]) m_flag[k] = 1;
                else if (take && s == ext_at[k]) m_flag[k] = 0;
                m_prev[k] = ext_pin_n[k];
            end
            if (cpu_reti) begin
                if (m_hi) m_hi = 0;
                else if (m_lo) m_lo = 0;
            end else if (take) begin
                if (h) m_hi = 1;
                else m_lo = 1;
            end
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        bit v, h;
        int s;
        bit [3:0] ef;
        if (chk_on) begin
            model_win(v, s, h);
            for (int k = 0; k < 4; k++) ef[k] = m_flag[k];
            check("R4", "irq_req", int'(irq_req), int'(v));
            if (v) check("R3", "irq_vector", int'(irq_vector), s * 8 + 3);
            check("R5", "ext_flag", int'(ext_flag), int'(ef));
            check("R8", "svc_lo", int'(svc_lo), int'(m_lo));
            check("R8", "svc_hi", int'(svc_hi), int'(m_hi));
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_ack();
        cpu_ack = 1; tick(1); cpu_ack = 0;
    endtask

    task automatic pulse_reti();
        cpu_reti = 1; tick(1); cpu_reti = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        tick(1);
        chk_on = 1;
        tick(2);
        rst_n = 1;
        tick(1);
        // R1: outputs idle after reset
        check("R1", "reset state", int'({irq_req, ext_flag, svc_lo, svc_hi}), 0);

        // R4: global enable off masks everything
        src_en = 8'hFF; tmr0_ovf = 1; tmr1_ovf = 1; uart_req = 1; tmr2_ovf = 1;
        tick(3);
        check("R4", "gated req", int'(irq_req), 0);

        // R3: lowest slot wins within one level
        glob_en = 1;
        tick(1);
        check("R3", "lowest slot", int'(irq_vector), 8'h0B);

        // R2: walk every slot alone, level-mode pins held low
        tmr0_ovf = 0; tmr1_ovf = 0; uart_req = 0; tmr2_ovf = 0;
        ext_pin_n = 4'h0; tmr0_ovf = 1; tmr1_ovf = 1; uart_req = 1; tmr2_ovf = 1;
        for (int s = 0; s < 8; s++) begin
            src_en = 8'(1 << s);
            tick(1);
            check("R2", "slot vector", int'(irq_vector), s * 8 + 3);
        end
        ext_pin_n = 4'hF; tmr0_ovf = 0; tmr1_ovf = 0; uart_req = 0; tmr2_ovf = 0;
        src_en = 8'hFF;

        // R7: timer2 external flag alone requests slot 5 and stays pending
        tmr2_ext = 1;
        tick(4);
        check("R7", "t2 ext", int'(irq_vector), 8'h2B);
        tmr2_ext = 0;

        // R8, R9: low service, high preempts, unnest, return
        uart_req = 1;
        tick(1);
        pulse_ack();
        check("R8", "enter low", int'({svc_lo, svc_hi}), 2'b10);
        check("R9", "low blocks low", int'(irq_req), 0);
        tmr1_ovf = 1; src_hi = 8'h08;
        tick(1);
        check("R9", "high preempts", int'(irq_vector), 8'h1B);
        pulse_ack();
        check("R8", "nest", int'({svc_lo, svc_hi}), 2'b11);
        check("R9", "nest blocks", int'(irq_req), 0);
        tmr1_ovf = 0;
        pulse_reti();
        check("R8", "unnest", int'({svc_lo, svc_hi}), 2'b10);
        pulse_reti();
        check("R8", "return", int'({svc_lo, svc_hi}), 2'b00);
        uart_req = 0; src_hi = 0;

        // R5, R6: falling edge on ext2 latches, ack clears
        ext_edge_mode = 4'hF;
        tick(1);
        ext_pin_n[2] = 0;
        tick(1);
        check("R5", "edge latched", int'(ext_flag[2]), 1);
        ext_pin_n[2] = 1;
        tick(1);
        check("R6", "flag holds", int'(irq_vector), 8'h33);
        pulse_ack();
        check("R6", "flag cleared", int'(ext_flag[2]), 0);
        pulse_reti();

        // R5: level mode does not latch
        ext_edge_mode = 4'h0;
        ext_pin_n[3] = 0;
        tick(1);
        check("R5", "level req", int'(irq_vector), 8'h3B);
        ext_pin_n[3] = 1;
        tick(1);
        check("R5", "level no latch", int'(irq_req), 0);

        // R10: ignored strobes
        pulse_ack();
        check("R10", "ack w/o req", int'({svc_lo, svc_hi}), 0);
        pulse_reti();
        check("R10", "reti idle", int'({svc_lo, svc_hi}), 0);
        uart_req = 1;
        cpu_ack = 1; cpu_reti = 1; tick(1); cpu_ack = 0; cpu_reti = 0;
        check("R10", "ack with reti", int'({svc_lo, svc_hi}), 0);
        uart_req = 0;

        // random phase, compared every clock against the reference
        for (int n = 0; n < 4000; n++) begin
            glob_en = ($urandom_range(0, 9) != 0);
            src_en = 8'($urandom);
            src_hi = 8'($urandom);
            ext_edge_mode = 4'($urandom);
            ext_pin_n = 4'($urandom) | 4'($urandom);
            {tmr0_ovf, tmr1_ovf, uart_req} = 3'($urandom) & 3'($urandom);
            tmr2_ovf = ($urandom_range(0, 3) == 0);
            tmr2_ext = ($urandom_range(0, 3) == 0);
            cpu_ack = ($urandom_range(0, 2) == 0);
            cpu_reti = ($urandom_range(0, 3) == 0);
            tick(1);
        end
        cpu_ack = 0; cpu_reti = 0;
        tick(2);
        summary();
        $finish;
    end
endmodule